// File: doc/BRIEF.md
# Temperature-Aware Operating Point Selector

This controller chooses a supply-level code and a threshold-setting code for one buffered interconnect domain, once per programmable decision epoch. At the start of an epoch it samples a quantized temperature code and maps it to one of eight temperature bins. Each bin has a row of candidate setting pairs in a lookup table, with the delay and energy of each pair stored beside it and the row sorted by ascending delay. Each bin also holds a nominal pair with its delay and a slack fraction.

From the bin's nominal delay and slack the block derives a delay ceiling. It walks the row from the fastest candidate and stops at the first entry that exceeds the ceiling. Among the entries it has passed, it keeps the one with the lowest energy. The chosen pair goes to a voltage-scaling unit and stays presented with a valid flag until that unit acknowledges it. No arithmetic model runs at decision time. A single write port fills all tables, the bin thresholds, the slack values and the epoch length.

Top module: `op_point_selector`

## Requirements
- R1: While reset is asserted, and after reset is released until the first decision, `op_valid` is 0 and the output codes equal the parameters `NOM_VDD` and `NOM_VTH`.
- R2: The bin is the largest b in 1..7 for which the sampled temperature is at or above the threshold of bin b, and bin 0 if there is no such b. Codes below every threshold therefore fall into bin 0, and codes above every threshold fall into bin 7.
- R3: A decision starts once the block has been idle for the programmed epoch length in cycles. The temperature is sampled only at that start, so a temperature change during the scan does not affect the result. The output codes change only when a new result is presented.
- R4: The delay ceiling equals nominal + ((nominal × slack) >> 8), with a 16-bit nominal delay and an 8-bit slack. The ceiling saturates at 0xFFFF and is never below the nominal delay.
- R5: A candidate is admissible when its delay is at or below the ceiling. The scan stops at the first candidate, in index order, whose delay is above the ceiling, and no later entry is considered.
- R6: Among the admissible candidates, the pair with the lowest stored energy is output.
- R7: When two admissible candidates have equal energy, the one with the lower index wins.
- R8: When no candidate is admissible, the nominal pair of the sampled bin is output.
- R9: `op_valid` stays high with stable codes until `op_ack` is seen. It is low on the cycle after the acknowledge.
- R10: Table writes are selected by `wr_kind`. Kind 0 writes candidate (`wr_bin`, `wr_idx`) and kind 1 writes the bin's nominal entry, both with data {vth[39:36], vdd[35:32], energy[31:16], delay[15:0]}. Kind 2 writes the bin's threshold from data[6:0] and its slack from data[15:8]. Kind 3 writes the epoch length from data[15:0].
- R11: Counting from the cycle after an acknowledge, the result appears no earlier than epoch+4 cycles and no later than epoch+NCAND+3 cycles.
- R12: A reset that arrives during a scan abandons the scan. It clears `op_valid` and drives the nominal parameter codes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_code | input | 7 | Quantized temperature, unsigned degrees |
| wr_en | input | 1 | Table write strobe |
| wr_kind | input | 2 | Write target selector |
| wr_bin | input | 3 | Bin addressed by the write |
| wr_idx | input | 3 | Candidate index addressed by the write |
| wr_data | input | 40 | Write payload |
| op_ack | input | 1 | Acknowledge from the voltage-scaling unit |
| op_valid | output | 1 | Result presented |
| op_vdd | output | 4 | Selected supply-level code |
| op_vth | output | 4 | Selected threshold-setting code |

## Verification
A wrong bin index, ceiling or running minimum inside the block shows up at the ports as a wrong code pair, one epoch plus at most eleven cycles after the previous acknowledge. The special tables are built so that each fault gives a different pair from the correct one: a bound that wraps instead of saturating, a scan that does not stop early, a tie broken the wrong way, and a missing nominal fallback. A temperature change is injected during the scan to expose late sampling. A reset is applied during a scan, and the outputs must show the reset codes in the same cycle.

// File: rtl/opsel_pkg.sv
package opsel_pkg;
    parameter int TEMP_W  = 7;
    parameter int NBINS   = 8;
    parameter int NCAND   = 8;
    parameter int VAL_W   = 16;
    parameter int SIG_W   = 8;
    parameter int CODE_W  = 4;
    parameter int EPOCH_W = 16;

    localparam int BIN_W   = $clog2(NBINS);
    localparam int IDX_W   = $clog2(NCAND);
    localparam int WR_W    = 2 * VAL_W + 2 * CODE_W;
    localparam int SIG_LSB = 8;

    typedef struct packed {
        logic [CODE_W-1:0] vth;
        logic [CODE_W-1:0] vdd;
        logic [VAL_W-1:0]  energy;
        logic [VAL_W-1:0]  delay;
    } pair_ent_t;

    typedef enum logic [1:0] {
        WK_CAND  = 2'd0,
        WK_NOM   = 2'd1,
        WK_BIN   = 2'd2,
        WK_EPOCH = 2'd3
    } wr_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SCAN,
        ST_PICK,
        ST_PRESENT
    } sel_state_e;
endpackage

// File: rtl/opsel_tables.sv
module opsel_tables
    import opsel_pkg::*;
#(
    parameter logic [CODE_W-1:0]  NOM_VDD   = 4'd9,
    parameter logic [CODE_W-1:0]  NOM_VTH   = 4'd3,
    parameter logic [EPOCH_W-1:0] DEF_EPOCH = 16'd1000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_kind,
    input  logic [BIN_W-1:0]              wr_bin,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [WR_W-1:0]               wr_data,
    input  logic [BIN_W-1:0]              rd_bin,
    input  logic [IDX_W-1:0]              rd_idx,
    output pair_ent_t                     cand_rd,
    output pair_ent_t                     nom_rd,
    output logic [SIG_W-1:0]              sig_rd,
    output logic [NBINS-1:0][TEMP_W-1:0]  thr_o,
    output logic [EPOCH_W-1:0]            epoch_len_o
);
    localparam int THR_STEP = (1 << TEMP_W) / NBINS;

    pair_ent_t                    cand_d [NBINS][NCAND];
    pair_ent_t                    cand_q [NBINS][NCAND];
    pair_ent_t                    nom_d  [NBINS];
    pair_ent_t                    nom_q  [NBINS];
    logic [NBINS-1:0][TEMP_W-1:0] thr_d, thr_q;
    logic [NBINS-1:0][SIG_W-1:0]  sig_d, sig_q;
    logic [EPOCH_W-1:0]           epoch_d, epoch_q;

    wr_kind_e kind;
    assign kind = wr_kind_e'(wr_kind);

    always_comb begin
        cand_d  = cand_q;
        nom_d   = nom_q;
        thr_d   = thr_q;
        sig_d   = sig_q;
        epoch_d = epoch_q;
        if (wr_en) begin
            case (kind)
                WK_CAND:  cand_d[wr_bin][wr_idx] = pair_ent_t'(wr_data);
                WK_NOM:   nom_d[wr_bin] = pair_ent_t'(wr_data);
                WK_BIN: begin
                    thr_d[wr_bin] = wr_data[TEMP_W-1:0];
                    sig_d[wr_bin] = wr_data[SIG_LSB+SIG_W-1:SIG_LSB];
                end
                default:  epoch_d = wr_data[EPOCH_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NBINS; b++) begin
                for (int i = 0; i < NCAND; i++) begin
                    cand_q[b][i] <= '0;
                end
                nom_q[b] <= '{vth: NOM_VTH, vdd: NOM_VDD, energy: '0, delay: '0};
                thr_q[b] <= TEMP_W'(b * THR_STEP);
                sig_q[b] <= '0;
            end
            epoch_q <= DEF_EPOCH;
        end else begin
            cand_q  <= cand_d;
            nom_q   <= nom_d;
            thr_q   <= thr_d;
            sig_q   <= sig_d;
            epoch_q <= epoch_d;
        end
    end

    assign cand_rd     = cand_q[rd_bin][rd_idx];
    assign nom_rd      = nom_q[rd_bin];
    assign sig_rd      = sig_q[rd_bin];
    assign thr_o       = thr_q;
    assign epoch_len_o = epoch_q;
endmodule

// File: rtl/opsel_bin_map.sv
module opsel_bin_map
    import opsel_pkg::*;
(
    input  logic [TEMP_W-1:0]             temp,
    input  logic [NBINS-1:0][TEMP_W-1:0]  thr,
    output logic [BIN_W-1:0]              bin
);
    logic [NBINS-1:0] at_or_above;

    generate
        for (genvar g = 0; g < NBINS; g++) begin : g_cmp
            if (g == 0) begin : g_floor
                assign at_or_above[g] = 1'b1;
            end else begin : g_thr
                assign at_or_above[g] = (temp >= thr[g]);
            end
        end
    endgenerate

    always_comb begin
        bin = '0;
        for (int b = 1; b < NBINS; b++) begin
            if (at_or_above[b]) bin = BIN_W'(b);
        end
    end
endmodule

// File: rtl/opsel_bound.sv
module opsel_bound
    import opsel_pkg::*;
(
    input  logic [VAL_W-1:0] nom_delay,
    input  logic [SIG_W-1:0] sigma,
    output logic [VAL_W-1:0] bound
);
    logic [VAL_W+SIG_W-1:0] prod;
    logic [VAL_W-1:0]       inc;
    logic [VAL_W:0]         sum;

    always_comb begin
        prod  = VAL_W'(nom_delay) * SIG_W'(sigma);
        inc   = prod[VAL_W+SIG_W-1:SIG_W];
        sum   = {1'b0, nom_delay} + {1'b0, inc};
        bound = sum[VAL_W] ? {VAL_W{1'b1}} : sum[VAL_W-1:0];
    end
endmodule

// File: rtl/op_point_selector.sv
module op_point_selector
    import opsel_pkg::*;
#(
    parameter logic [CODE_W-1:0]  NOM_VDD   = 4'd9,
    parameter logic [CODE_W-1:0]  NOM_VTH   = 4'd3,
    parameter logic [EPOCH_W-1:0] DEF_EPOCH = 16'd1000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TEMP_W-1:0]  temp_code,
    input  logic               wr_en,
    input  logic [1:0]         wr_kind,
    input  logic [BIN_W-1:0]   wr_bin,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WR_W-1:0]    wr_data,
    input  logic               op_ack,
    output logic               op_valid,
    output logic [CODE_W-1:0]  op_vdd,
    output logic [CODE_W-1:0]  op_vth
);
    typedef struct packed {
        sel_state_e         state;
        logic [EPOCH_W-1:0] cnt;
        logic [BIN_W-1:0]   bin;
        logic [IDX_W-1:0]   idx;
        logic [VAL_W-1:0]   bound;
        logic               have;
        logic [VAL_W-1:0]   best_e;
        logic [CODE_W-1:0]  best_vdd;
        logic [CODE_W-1:0]  best_vth;
        logic               valid;
        logic [CODE_W-1:0]  out_vdd;
        logic [CODE_W-1:0]  out_vth;
    } sel_t;

    sel_t s_d, s_q;

    pair_ent_t                    cand_rd, nom_rd;
    logic [SIG_W-1:0]             sig_rd;
    logic [NBINS-1:0][TEMP_W-1:0] thr;
    logic [EPOCH_W-1:0]           epoch_len;
    logic [BIN_W-1:0]             bin_now;
    logic [VAL_W-1:0]             bound_w;
    logic [EPOCH_W-1:0]           epoch_last;

    opsel_tables #(
        .NOM_VDD  (NOM_VDD),
        .NOM_VTH  (NOM_VTH),
        .DEF_EPOCH(DEF_EPOCH)
    ) u_tables (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_kind    (wr_kind),
        .wr_bin     (wr_bin),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .rd_bin     (s_q.bin),
        .rd_idx     (s_q.idx),
        .cand_rd    (cand_rd),
        .nom_rd     (nom_rd),
        .sig_rd     (sig_rd),
        .thr_o      (thr),
        .epoch_len_o(epoch_len)
    );

    opsel_bin_map u_bin_map (
        .temp(temp_code),
        .thr (thr),
        .bin (bin_now)
    );

    opsel_bound u_bound (
        .nom_delay(nom_rd.delay),
        .sigma    (sig_rd),
        .bound    (bound_w)
    );

    assign epoch_last = (epoch_len == '0) ? '0 : epoch_len - 1'b1;

    always_comb begin
        s_d = s_q;
        case (s_q.state)
            ST_IDLE: begin
                if (s_q.cnt >= epoch_last) begin
                    s_d.cnt   = '0;
                    s_d.bin   = bin_now;
                    s_d.state = ST_SETUP;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_SETUP: begin
                s_d.bound  = bound_w;
                s_d.idx    = '0;
                s_d.have   = 1'b0;
                s_d.best_e = '1;
                s_d.state  = ST_SCAN;
            end
            ST_SCAN: begin
                if (cand_rd.delay > s_q.bound) begin
                    s_d.state = ST_PICK;
                end else begin
                    if (!s_q.have || (cand_rd.energy < s_q.best_e)) begin
                        s_d.have     = 1'b1;
                        s_d.best_e   = cand_rd.energy;
                        s_d.best_vdd = cand_rd.vdd;
                        s_d.best_vth = cand_rd.vth;
                    end
                    if (s_q.idx == IDX_W'(NCAND - 1)) begin
                        s_d.state = ST_PICK;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            ST_PICK: begin
                s_d.valid   = 1'b1;
                s_d.out_vdd = s_q.have ? s_q.best_vdd : nom_rd.vdd;
                s_d.out_vth = s_q.have ? s_q.best_vth : nom_rd.vth;
                s_d.state   = ST_PRESENT;
            end
            default: begin
                if (op_ack) begin
                    s_d.valid = 1'b0;
                    s_d.cnt   = '0;
                    s_d.state = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.state   <= ST_IDLE;
            s_q.out_vdd <= NOM_VDD;
            s_q.out_vth <= NOM_VTH;
        end else begin
            s_q <= s_d;
        end
    end

    assign op_valid = s_q.valid;
    assign op_vdd   = s_q.out_vdd;
    assign op_vth   = s_q.out_vth;

    // Checker-side cycle count of a decision in flight (SETUP, SCAN, PICK).
    logic [7:0] busy_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else if (s_q.state == ST_SETUP || s_q.state == ST_SCAN || s_q.state == ST_PICK) begin
            busy_q <= busy_q + 1'b1;
        end else begin
            busy_q <= '0;
        end
    end

    a_r9_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ack) |=> (op_valid && $stable(op_vdd) && $stable(op_vth)));

    a_r9_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ack) |=> !op_valid);

    a_r3_codes_change_on_result: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({op_vdd, op_vth}) |-> $rose(op_valid));

    a_r4_bound_not_below_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_SCAN) |-> (s_q.bound >= nom_rd.delay));

    a_r11_scan_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q <= 8'(NCAND + 2));
endmodule

// File: tb/op_point_selector_bench.sv
`timescale 1ns/1ps
module op_point_selector_bench;
    import opsel_pkg::*;

    localparam logic [3:0] P_NOM_VDD = 4'd9;
    localparam logic [3:0] P_NOM_VTH = 4'd3;
    localparam int         EPOCH     = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TEMP_W-1:0] temp_code = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_kind = '0;
    logic [BIN_W-1:0]  wr_bin = '0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [WR_W-1:0]   wr_data = '0;
    logic              op_ack = 1'b0;
    logic              op_valid;
    logic [CODE_W-1:0] op_vdd, op_vth;

    always #2.5 clk = ~clk;

    op_point_selector #(.NOM_VDD(P_NOM_VDD), .NOM_VTH(P_NOM_VTH)) u_op_point_selector (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .wr_en(wr_en),
        .wr_kind(wr_kind), .wr_bin(wr_bin), .wr_idx(wr_idx), .wr_data(wr_data),
        .op_ack(op_ack), .op_valid(op_valid), .op_vdd(op_vdd), .op_vth(op_vth)
    );

    // Reference tables kept by the bench.
    int m_d [NBINS][NCAND];
    int m_e [NBINS][NCAND];
    int m_v [NBINS][NCAND];
    int m_t [NBINS][NCAND];
    int m_nd[NBINS];
    int m_nv[NBINS];
    int m_nt[NBINS];
    int m_thr[NBINS];
    int m_sig[NBINS];

    int    n_chk = 0, n_fail = 0, n_done = 0;
    int    cyc = 0, last_ack = 0;
    bit    have_ref = 0, finished = 0;
    int    expq[$];
    string tagq[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic wr(input int kind, input int b, input int i, input logic [WR_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 2'(kind); wr_bin = BIN_W'(b); wr_idx = IDX_W'(i); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic put_cand(input int b, input int i, input int d, input int e, input int v, input int t);
        m_d[b][i] = d; m_e[b][i] = e; m_v[b][i] = v; m_t[b][i] = t;
        wr(0, b, i, {4'(t), 4'(v), 16'(e), 16'(d)});
    endtask

    task automatic put_nom(input int b, input int d, input int v, input int t);
        m_nd[b] = d; m_nv[b] = v; m_nt[b] = t;
        wr(1, b, 0, {4'(t), 4'(v), 16'd0, 16'(d)});
    endtask

    task automatic put_bin(input int b, input int thr, input int sig);
        m_thr[b] = thr; m_sig[b] = sig;
        wr(2, b, 0, WR_W'({8'(sig), 1'b0, 7'(thr)}));
    endtask

    // Expected {vdd,vth} from the requirements.
    function automatic int model(input int t);
        int bin, bound, best_e, res;
        bit have;
        bin = 0;
        for (int b = 1; b < NBINS; b++) if (t >= m_thr[b]) bin = b;                 // R2
        bound = m_nd[bin] + ((m_nd[bin] * m_sig[bin]) >> 8);                         // R4
        if (bound > 65535) bound = 65535;
        have = 0; best_e = 0; res = 0;
        for (int i = 0; i < NCAND; i++) begin
            if (m_d[bin][i] > bound) break;                                          // R5
            if (!have || m_e[bin][i] < best_e) begin                                 // R6, R7
                have = 1; best_e = m_e[bin][i]; res = m_v[bin][i] * 16 + m_t[bin][i];
            end
        end
        if (!have) res = m_nv[bin] * 16 + m_nt[bin];                                 // R8
        return res;
    endfunction

    // Monitor: pops expected items, checks hold, acknowledge and latency.
    initial begin
        int got, exp, lat;
        string tag;
        forever begin
            @(negedge clk);
            if (rst_n && op_valid) begin
                got = int'(op_vdd) * 16 + int'(op_vth);
                if (have_ref) begin
                    lat = cyc - last_ack;
                    chk(lat >= EPOCH + 4 && lat <= EPOCH + NCAND + 3, "R11", "latency after ack", lat, EPOCH + 4);
                end
                if (expq.size() == 0) begin
                    chk(1'b0, "R3", "result without a decision", got, -1);
                end else begin
                    exp = expq.pop_front();
                    tag = tagq.pop_front();
                    chk(got == exp, tag, "selected pair {vdd,vth}", got, exp);
                end
                @(negedge clk); @(negedge clk);
                chk(op_valid && (int'(op_vdd) * 16 + int'(op_vth)) == got, "R9", "held before ack",
                    int'(op_valid), 1);
                op_ack = 1'b1;
                last_ack = cyc;
                @(negedge clk);
                op_ack = 1'b0;
                chk(!op_valid, "R9", "valid after ack", int'(op_valid), 0);
                have_ref = 1;
                n_done++;
            end
        end
    end

    task automatic run_case(input int t, input string tag, input bit kick, input bit late, input int late_t);
        int target;
        target = n_done + 1;
        expq.push_back(model(t));
        tagq.push_back(tag);
        temp_code = 7'(t);
        if (kick) wr(3, 0, 0, WR_W'(EPOCH));                                         // R10 epoch write
        if (late) begin
            while (cyc != last_ack + EPOCH + 2) @(negedge clk);
            temp_code = 7'(late_t);                                                  // R3: during scan
        end
        while (n_done < target) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            report();
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(!op_valid, "R1", "valid in reset", int'(op_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!op_valid, "R1", "valid after reset", int'(op_valid), 0);
        chk(op_vdd == P_NOM_VDD && op_vth == P_NOM_VTH, "R1", "codes after reset",
            int'(op_vdd) * 16 + int'(op_vth), int'(P_NOM_VDD) * 16 + int'(P_NOM_VTH));

        // Base contents (R10)
        for (int b = 0; b < NBINS; b++) begin
            for (int i = 0; i < NCAND; i++)
                put_cand(b, i, 100 + 20 * i + b, 1000 - ((i * 5 + b * 3) % 8) * 50, i, b);
            put_nom(b, 140 + b, 15, b);
        end
        put_bin(0, 0, 0);
        put_bin(1, 22, 64);
        put_bin(2, 34, 128);
        put_bin(3, 46, 200);
        put_bin(4, 58, 136);
        put_bin(5, 70, 64);
        put_bin(6, 82, 0);
        put_bin(7, 94, 255);
        // Bin 4: out-of-order entry after a rejected one (R5)
        put_cand(4, 4, 230, m_e[4][4], 4, 4);
        put_cand(4, 5, 210, 10, 5, 4);
        // Bin 5: equal energies (R7)
        put_cand(5, 0, m_d[5][0], 900, 0, 5);
        put_cand(5, 1, m_d[5][1], 300, 1, 5);
        put_cand(5, 2, m_d[5][2], 300, 2, 5);
        put_cand(5, 3, m_d[5][3], 600, 3, 5);
        // Bin 6: nothing admissible (R8)
        put_nom(6, 50, 15, 6);
        // Bin 7: ceiling saturates (R4)
        put_nom(7, 16'hF000, 15, 7);
        put_cand(7, 7, 16'hFFFF, 5, 7, 7);

        run_case(5,   "R2 clamp low / R6 min energy", 1'b1, 1'b0, 0);
        run_case(22,  "R2 threshold equality",        1'b0, 1'b0, 0);
        run_case(33,  "R10 written threshold",        1'b0, 1'b0, 0);
        run_case(60,  "R5 prefix stop",               1'b0, 1'b0, 0);
        run_case(70,  "R7 tie to lower index",        1'b0, 1'b0, 0);
        run_case(85,  "R8 nominal fallback",          1'b0, 1'b0, 0);
        run_case(127, "R4 saturated ceiling",         1'b0, 1'b0, 0);
        run_case(47,  "R3 sample at epoch start",     1'b0, 1'b1, 127);

        // R12: reset during a scan
        temp_code = 7'd100;
        while (cyc != last_ack + EPOCH + 2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(!op_valid, "R12", "valid on mid-scan reset", int'(op_valid), 0);
        chk(op_vdd == P_NOM_VDD && op_vth == P_NOM_VTH, "R12", "codes on mid-scan reset",
            int'(op_vdd) * 16 + int'(op_vth), int'(P_NOM_VDD) * 16 + int'(P_NOM_VTH));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!op_valid && op_vdd == P_NOM_VDD, "R12", "nominal held after reset",
            int'(op_vdd), int'(P_NOM_VDD));

        finished = 1;
        report();
        $finish;
    end
endmodule